// File: doc/BRIEF.md
# Trigger Combiner and Capture Controller

This block sits behind a bank of probe comparators in an on-chip logic analyzer. Each clock it folds the comparators' match bits into one trigger event. A run-time mode input picks whether every enabled comparator must match (AND) or whether one is enough (OR). A per-probe enable mask removes unused comparators from the vote.

Once armed, the controller waits for the trigger. It writes the probe word from the trigger cycle into the sample buffer at address 0. It then keeps writing one word per clock until the buffer holds exactly its depth in samples. At that point the buffer is frozen, and it can be uploaded through a request/response read port until the next arm. Every register, including the inferred single-clock RAM, runs on the one design clock.

The read port is a stream. A request is a valid/ready handshake that carries an address. The controller accepts requests only while the capture is complete, and it holds ready low at all other times. The response comes back with a valid flag one cycle after acceptance and has no ready input, so the consumer must take it in that cycle. To keep its place, a consumer stalls by leaving `rd_req_valid` low.

Top module: `trig_capture`

## Requirements
- R1: After reset `status` is 0 (idle), `rd_req_ready` is 0 and `rd_resp_valid` is 0.
- R2: `status` is 0 idle, 1 armed, 2 capturing, 3 done. In idle or done, `arm` high moves the controller to armed on the next cycle. In armed or capturing, `arm` is ignored.
- R3: While armed with `and_mode`=1, the controller moves to capturing on the next cycle only in a cycle where every enabled probe's match bit is 1.
- R4: While armed with `and_mode`=0, the controller moves to capturing on the next cycle in a cycle where at least one enabled probe's match bit is 1.
- R5: A probe whose `probe_use` bit is 0 counts as matched in AND mode and as unmatched in OR mode. With no probe enabled, AND mode triggers in the first armed cycle and OR mode never triggers.
- R6: The probe word present in the trigger cycle is stored at address 0. The word from the k-th cycle after it is stored at address k.
- R7: Exactly DEPTH samples are written. The controller reports done in the cycle after the sample for address DEPTH-1 is written.
- R8: In done, `rd_req_ready` is 1. A request accepted in one cycle returns the stored word at `rd_addr` on `rd_resp_data` with `rd_resp_valid`=1 in the next cycle.
- R9: Outside done, `rd_req_ready` is 0, and no response is produced whatever `rd_req_valid` does.
- R10: In done, the buffer contents do not change with `probe_data` or `match`. Only a new arm followed by a trigger overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock for all trigger and storage logic |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm request, honoured in idle or done |
| and_mode | input | 1 | 1 = AND of enabled matches, 0 = OR |
| probe_use | input | NUM_PROBES | Per-probe enable for the trigger vote |
| match | input | NUM_PROBES | Comparator match bits, one per probe |
| probe_data | input | DATA_W | Concatenated probe word sampled each cycle |
| status | output | 2 | Controller state (R2 encoding) |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request ready (high only in done) |
| rd_addr | input | $clog2(DEPTH) | Sample address of the read request |
| rd_resp_valid | output | 1 | Read response valid, one cycle after acceptance |
| rd_resp_data | output | DATA_W | Stored sample returned by the read |

## Verification
The assertions assume that `rst_n` is held low through the first clock edge, and that all inputs are settled, with no X, at each rising edge. They also assume that `rd_addr` stays inside the buffer, which holds by its width. The stimulus changes every input only on the falling edge and keeps reset low for several cycles at the start. The address stays within the range $clog2(DEPTH) can express. The run covers both combine modes with partial, full and empty enable masks. It also drives read requests in every state, so the ready/valid rules are tested where requests must be refused as well as where they are accepted.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_DONE    = 2'd3
  } cap_state_e;

endpackage

// File: rtl/trig_combine.sv
module trig_combine #(
  parameter int NUM_PROBES = 4
) (
  input  logic                  and_mode,
  input  logic [NUM_PROBES-1:0] probe_use,
  input  logic [NUM_PROBES-1:0] match,
  output logic                  hit
);

  logic [NUM_PROBES-1:0] eff;

  // Disabled probes take the neutral value of the selected reduction.
  for (genvar i = 0; i < NUM_PROBES; i++) begin : g_eff
    assign eff[i] = probe_use[i] ? match[i] : and_mode;
  end

  always_comb begin
    if (and_mode) hit = &eff;
    else          hit = |eff;
  end

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import trig_capture_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          hit,
  output cap_state_e    state,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cap_state_e    state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    wr_en   = 1'b0;
    wr_addr = ptr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (arm) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (hit) begin
          wr_en   = 1'b1;
          wr_addr = '0;
          ptr_d   = AW'(1);
          state_d = ST_CAPTURE;
        end
      end
      ST_CAPTURE: begin
        wr_en = 1'b1;
        if (ptr_q == LAST) state_d = ST_DONE;
        else               ptr_d   = ptr_q + AW'(1);
      end
      ST_DONE: begin
        if (arm) begin
          state_d = ST_ARMED;
          ptr_d   = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/sample_ram.sv
module sample_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import trig_capture_pkg::*;
#(
  parameter int NUM_PROBES = 4,
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm,
  input  logic                     and_mode,
  input  logic [NUM_PROBES-1:0]    probe_use,
  input  logic [NUM_PROBES-1:0]    match,
  input  logic [DATA_W-1:0]        probe_data,
  output logic [1:0]               status,
  input  logic                     rd_req_valid,
  output logic                     rd_req_ready,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic                     rd_resp_valid,
  output logic [DATA_W-1:0]        rd_resp_data
);

  localparam int AW = $clog2(DEPTH);

  if (NUM_PROBES < 1 || NUM_PROBES > 1024) begin : g_bad_probes
    $error("NUM_PROBES out of range");
  end
  if (DEPTH < 1024 || DEPTH > 131072 || (1 << AW) != DEPTH) begin : g_bad_depth
    $error("DEPTH must be a power of two in 1024..131072");
  end

  logic          hit;
  cap_state_e    state;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          rd_fire;

  trig_combine #(.NUM_PROBES(NUM_PROBES)) u_comb (
    .and_mode (and_mode),
    .probe_use(probe_use),
    .match    (match),
    .hit      (hit)
  );

  cap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (arm),
    .hit    (hit),
    .state  (state),
    .wr_en  (wr_en),
    .wr_addr(wr_addr)
  );

  assign rd_req_ready = (state == ST_DONE);
  assign rd_fire      = rd_req_valid && rd_req_ready;

  sample_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(probe_data),
    .re   (rd_fire),
    .raddr(rd_addr),
    .rdata(rd_resp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_resp_valid <= 1'b0;
    else        rd_resp_valid <= rd_fire;
  end

  assign status = state;

endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
  parameter int NUM_PROBES = 4,
  parameter int DEPTH      = 1024
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  arm,
  input logic                  and_mode,
  input logic [NUM_PROBES-1:0] probe_use,
  input logic [NUM_PROBES-1:0] match,
  input logic [1:0]            status,
  input logic                  rd_req_valid,
  input logic                  rd_req_ready,
  input logic                  rd_resp_valid,
  input logic                  wr_en
);

  logic [31:0] cap_cycles;

  always_ff @(posedge clk) begin
    if (!rst_n)              cap_cycles <= '0;
    else if (status == 2'd2) cap_cycles <= cap_cycles + 32'd1;
    else                     cap_cycles <= '0;
  end

  a_r2_arm_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0 && arm) |=> status == 2'd1);
  a_r2_arm_done: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd3 && arm) |=> status == 2'd1);
  a_r2_idle_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0 && !arm) |=> status == 2'd0);
  a_r3_and_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1 && and_mode && (&(match | ~probe_use))) |=> status == 2'd2);
  a_r3_and_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1 && and_mode && !(&(match | ~probe_use))) |=> status == 2'd1);
  a_r4_or_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1 && !and_mode && (|(match & probe_use))) |=> status == 2'd2);
  a_r4_or_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1 && !and_mode && !(|(match & probe_use))) |=> status == 2'd1);
  a_r7_keep_capturing: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2 && cap_cycles < 32'(DEPTH - 2)) |=> status == 2'd2);
  a_r7_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2 && cap_cycles == 32'(DEPTH - 2)) |=> status == 2'd3);
  a_r8_response: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> rd_resp_valid);
  a_r9_no_response: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_req_ready) |=> !rd_resp_valid);
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd3) |-> !wr_en);

endmodule

bind trig_capture trig_capture_chk #(.NUM_PROBES(NUM_PROBES), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .arm          (arm),
  .and_mode     (and_mode),
  .probe_use    (probe_use),
  .match        (match),
  .status       (status),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_resp_valid(rd_resp_valid),
  .wr_en        (wr_en)
);

// File: tb/trig_capture_test.sv
`timescale 1ns/1ps
module trig_capture_test;
  localparam int NP = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1024;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, and_mode = 1'b1;
  logic [NP-1:0] probe_use = '1, match = '0;
  logic [DW-1:0] probe_data = '0;
  logic [1:0] status;
  logic rd_req_valid = 1'b0, rd_req_ready, rd_resp_valid;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_resp_data;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";
  bit started = 0;

  always #10 clk = ~clk;

  trig_capture #(.NUM_PROBES(NP), .DATA_W(DW), .DEPTH(DEPTH)) uut (.*);

  // behavioural reference
  int m_state = 0, m_cnt = 0;
  bit m_rv = 0;
  logic [DW-1:0] m_rd = '0;
  logic [DW-1:0] m_mem [DEPTH];

  function automatic bit model_hit();
    bit all_ok = 1, any_ok = 0;
    for (int i = 0; i < NP; i++)
      if (probe_use[i]) begin
        if (!match[i]) all_ok = 0;
        if (match[i]) any_ok = 1;
      end
    return and_mode ? all_ok : any_ok;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_rv = 0;
    end else begin
      m_rv = rd_req_valid && (m_state == 3);
      if (m_rv) m_rd = m_mem[rd_addr];
      case (m_state)
        0: if (arm) m_state = 1;
        1: if (model_hit()) begin m_mem[0] = probe_data; m_cnt = 1; m_state = 2; end
        2: begin
          m_mem[m_cnt] = probe_data;
          if (m_cnt == DEPTH - 1) m_state = 3; else m_cnt++;
        end
        default: if (arm) m_state = 1;
      endcase
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      cycles++;
      chk(status == 2'(m_state), "status (R2)", int'(status), m_state);
      chk(rd_req_ready == (m_state == 3), "req_ready (R9)", int'(rd_req_ready), int'(m_state == 3));
      chk(rd_resp_valid == m_rv, "resp_valid (R8)", int'(rd_resp_valid), int'(m_rv));
      if (m_rv) chk(rd_resp_data == m_rd, "resp_data (R6)", int'(rd_resp_data), int'(m_rd));
      if (cycles > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog R7: actual %0d expected <150000", cycles, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  always @(negedge clk) probe_data <= probe_data * 16'd5 + 16'd3;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (status != 2'd3 && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic read_at(input int a);
    @(negedge clk); rd_addr = AW'(a); rd_req_valid = 1;
    @(negedge clk); rd_req_valid = 0;
  endtask

  initial begin
    step(4);
    tag = "R1";
    chk(status == 2'd0 && !rd_req_ready && !rd_resp_valid, "reset state R1", int'(status), 0);
    rst_n = 1;

    tag = "R9";
    @(negedge clk); rd_req_valid = 1; step(3); rd_req_valid = 0;

    tag = "R3";
    and_mode = 1; probe_use = 4'b1111; match = 4'b0111;
    pulse_arm();
    step(3);
    tag = "R2"; arm = 1; step(1); arm = 0;
    tag = "R3"; match = 4'b1110; step(2);
    chk(status == 2'd1, "AND partial holds R3", int'(status), 1);
    match = 4'b1111; step(1); match = 4'b0000;
    tag = "R6"; step(5);
    tag = "R2"; arm = 1; step(1); arm = 0;
    tag = "R7"; wait_done();
    chk(status == 2'd3, "capture done R7", int'(status), 3);
    tag = "R10"; match = 4'b1111; step(20);
    tag = "R8";
    read_at(0); read_at(1); read_at(2); read_at(511); read_at(DEPTH - 1);
    @(negedge clk); rd_addr = 5; rd_req_valid = 1; step(4); rd_req_valid = 0;
    step(2);

    tag = "R5"; and_mode = 0; probe_use = 4'b0101; match = 4'b1010;
    pulse_arm(); step(4);
    chk(status == 2'd1, "OR ignores unused R5", int'(status), 1);
    tag = "R4"; match = 4'b0100; step(1); match = 4'b0000;
    wait_done();
    tag = "R8"; read_at(0); read_at(DEPTH / 2); read_at(DEPTH - 2);

    tag = "R5"; and_mode = 1; probe_use = 4'b0000; match = 4'b0000;
    pulse_arm(); step(1);
    chk(status == 2'd2, "AND empty mask fires R5", int'(status), 2);
    wait_done();
    tag = "R10"; read_at(3); read_at(1000);

    tag = "R5"; and_mode = 0; probe_use = 4'b0000; match = 4'b1111;
    pulse_arm(); step(30);
    chk(status == 2'd1, "OR empty mask never fires R5", int'(status), 1);
    tag = "R9"; @(negedge clk); rd_req_valid = 1; step(3); rd_req_valid = 0;
    step(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule